// File: doc/BRIEF.md
# Page Write Buffer Engine

This block sits behind a serial memory front end and gathers the data bytes of one write transfer into a small page buffer. A transfer opens with a start strobe and a target address. Each following byte lands at the next location of the same page. The location counter wraps inside the page, so bytes sent after the last location overwrite the earliest ones. When the front end reports that chip select has risen, the engine decides whether to commit or discard the gathered bytes. It commits only when at least one byte arrived and the rise fell exactly on a byte boundary.

On commit the engine raises a busy flag for a fixed number of clock cycles that stands in for the internal programming time. During the first part of that window it drains the buffer onto the array write port. It writes one byte per cycle, and only at the locations that received data. At the end of the window it drops the busy flag and pulses a request to clear the write enable latch. While the busy flag is high, the engine refuses both new write transfers and array read requests.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, `wip`, `wel_clr`, `arr_we` and `rd_grant` are all 0.
- R2: A `wr_start` seen while `wel_i` is 0 opens no transfer, so the bytes and chip select rise that follow cause no `wip` and no array write.
- R3: The first byte goes to in-page offset `wr_addr[4:0]` and each later byte to the next offset. The offset wraps from 31 to 0, and a later byte at an offset replaces the earlier one. The upper address bits `wr_addr[12:5]` select the page for all bytes.
- R4: A `cs_rise` with `bit_aligned` at 0, or one with no byte received, discards the transfer: `wip` stays 0 and nothing is written.
- R5: A `cs_rise` with `bit_aligned` at 1 after at least one byte sets `wip` on the following clock. `wip` then stays high for exactly `WR_CYCLES` cycles.
- R6: During `wip`, each touched location is written once on `arr_we`/`arr_addr`/`arr_wdata` in ascending in-page offset order, with its final byte. Untouched locations of the page are never written.
- R7: `wel_clr` is a single-cycle pulse in the first cycle after `wip` falls.
- R8: A `wr_start`, data bytes or a `cs_rise` presented while `wip` is high are ignored and cause no later commit.
- R9: `rd_grant` is high one cycle after a `rd_req` that was sampled while `wip` was low. It stays low after a `rd_req` sampled while `wip` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wel_i | input | 1 | Current state of the write enable latch |
| wr_start | input | 1 | Opens a write transfer at `wr_addr` |
| wr_addr | input | ADDR_W | Start address of the transfer |
| byte_vld | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select has just risen |
| bit_aligned | input | 1 | The rise came right after the last bit of a byte |
| rd_req | input | 1 | Array read request from the front end |
| wip | output | 1 | Internal write cycle in progress |
| wel_clr | output | 1 | Pulse that clears the write enable latch |
| rd_grant | output | 1 | Read request accepted |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench builds the engine with `WR_CYCLES` set to 40. This keeps each write cycle to a few dozen clocks, so the bench can run several commits and measure the exact busy length and latch-clear pulse. Address width and page size stay at their defaults of 13 and 32. That brings the top page at 0x1FE0 into reach, together with a wrap from offset 30 into offsets 0 and 1, and a 34-byte transfer that overwrites the first two locations of a full page.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic {
    PG_IDLE = 1'b0,
    PG_FILL = 1'b1
  } pg_state_t;
endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  rd_idx_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0]     mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] touched;

  // byte storage, no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched  <= '0;
      rd_hit   <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      if (clr) touched <= '0;
      else if (wr_en) touched[wr_idx] <= 1'b1;
      rd_hit   <= rd_en && touched[rd_idx];
      rd_idx_q <= rd_idx;
    end
  end

  // R8
  fill_drain_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
  // R6
  hit_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_hit);
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WR_CYCLES  = 500000,
  parameter int PAGE_BYTES = 32,
  localparam int CW        = $clog2(WR_CYCLES),
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             active,
  output logic             done,
  output logic             drain_en,
  output logic [IDX_W-1:0] drain_idx
);
  localparam logic [CW-1:0] LAST  = CW'(WR_CYCLES - 1);
  localparam logic [CW-1:0] DRAIN = CW'(PAGE_BYTES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) active <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    done      = active && (cnt == LAST);
    drain_en  = active && (cnt < DRAIN);
    drain_idx = cnt[IDX_W-1:0];
  end

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= LAST));
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  parameter int WR_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wel_i,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              bit_aligned,
  input  logic              rd_req,
  output logic              wip,
  output logic              wel_clr,
  output logic              rd_grant,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - IDX_W;

  pg_state_t         state;
  logic [IDX_W-1:0]  ptr;
  logic [BASE_W-1:0] base;
  logic              have_byte;

  logic start_ok, commit, fill_we;
  logic tmr_done, drain_en;
  logic [IDX_W-1:0] drain_idx, out_idx;

  always_comb begin
    start_ok = (state == PG_IDLE) && wr_start && wel_i && !wip;
    commit   = (state == PG_FILL) && cs_rise && bit_aligned && have_byte;
    fill_we  = (state == PG_FILL) && !cs_rise && byte_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PG_IDLE;
      ptr       <= '0;
      base      <= '0;
      have_byte <= 1'b0;
      wel_clr   <= 1'b0;
      rd_grant  <= 1'b0;
    end else begin
      wel_clr  <= tmr_done;
      rd_grant <= rd_req && !wip;
      case (state)
        PG_IDLE: if (start_ok) begin
          state     <= PG_FILL;
          base      <= wr_addr[ADDR_W-1:IDX_W];
          ptr       <= wr_addr[IDX_W-1:0];
          have_byte <= 1'b0;
        end
        PG_FILL: if (cs_rise) begin
          state <= PG_IDLE;
        end else if (byte_vld) begin
          ptr       <= ptr + 1'b1;
          have_byte <= 1'b1;
        end
        default: state <= PG_IDLE;
      endcase
    end
  end

  pgwr_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .clr      (start_ok),
    .wr_en    (fill_we),
    .wr_idx   (ptr),
    .wr_data  (byte_data),
    .rd_en    (drain_en),
    .rd_idx   (drain_idx),
    .rd_hit   (arr_we),
    .rd_idx_q (out_idx),
    .rd_data  (arr_wdata)
  );

  pgwr_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .start     (commit),
    .active    (wip),
    .done      (tmr_done),
    .drain_en  (drain_en),
    .drain_idx (drain_idx)
  );

  assign arr_addr = {base, out_idx};

  // R5
  wip_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(cs_rise && bit_aligned));
  // R7
  wel_clr_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> wel_clr);
  // R7
  wel_clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wel_clr |=> !wel_clr);
  // R9
  rd_block_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wip) |=> !rd_grant);
  // R6
  arr_in_wip_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> wip);
endmodule

// File: tb/pgwr_engine_tb.sv
module pgwr_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int NCYC = 40;

  logic clk = 0, rst = 1;
  logic wel_i = 0, wr_start = 0, byte_vld = 0, cs_rise = 0, bit_aligned = 0, rd_req = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] byte_data = '0;
  logic wip, wel_clr, rd_grant, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [AW+7:0] exp_q[$];

  // driver-side shadow of one transfer
  logic [7:0] sh_data [32];
  logic [31:0] sh_mask;
  logic [AW-6:0] sh_base;
  logic [4:0] sh_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwr_engine #(.ADDR_W(AW), .PAGE_BYTES(32), .DATA_W(8), .WR_CYCLES(NCYC)) u_dut (
    .clk(clk), .rst(rst), .wel_i(wel_i), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .bit_aligned(bit_aligned), .rd_req(rd_req), .wip(wip), .wel_clr(wel_clr),
    .rd_grant(rd_grant), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected array writes (R3, R6)
  always @(negedge clk) begin
    if (!rst && arr_we) begin
      if (exp_q.size() == 0) check("R6 unexpected write", {11'b0, arr_addr, arr_wdata}, 32'hFFFF_FFFF);
      else check("R3/R6 array write", {11'b0, arr_addr, arr_wdata}, {11'b0, exp_q.pop_front()});
    end
  end

  task automatic start_wr(input logic [AW-1:0] a, input logic wel, input bit model);
    @(negedge clk); wr_start = 1; wr_addr = a; wel_i = wel;
    @(negedge clk); wr_start = 0;
    if (model) begin sh_mask = '0; sh_base = a[AW-1:5]; sh_ptr = a[4:0]; end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit model);
    @(negedge clk); byte_vld = 1; byte_data = d;
    @(negedge clk); byte_vld = 0;
    if (model) begin sh_data[sh_ptr] = d; sh_mask[sh_ptr] = 1'b1; sh_ptr = sh_ptr + 1'b1; end
  endtask

  task automatic end_wr(input logic al, input bit model);
    if (model && al && sh_mask != 0)
      for (int i = 0; i < 32; i++)
        if (sh_mask[i]) exp_q.push_back({sh_base, 5'(i), sh_data[i]});
    @(negedge clk); cs_rise = 1; bit_aligned = al;
    @(negedge clk); cs_rise = 0; bit_aligned = 0;
  endtask

  // called at the negedge right after end_wr of a committed transfer
  task automatic measure_cycle(input string req);
    int n = 0;
    check("R5 wip set after commit", wip, 1);
    while (wip && n < 1000) begin n++; @(negedge clk); end
    check("R5 wip length", n, NCYC);
    check("R7 wel_clr at wip fall", wel_clr, 1);
    @(negedge clk);
    check("R7 wel_clr single pulse", wel_clr, 0);
    check({req, " all writes drained"}, exp_q.size(), 0);
  endtask

  task automatic idle_watch(input string req, input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (wip) begin check(req, wip, 0); break; end
    end
    check(req, wip, 0);
  endtask

  task automatic read_try(input logic exp, input string req);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    check(req, rd_grant, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 wip reset", wip, 0);
    check("R1 wel_clr reset", wel_clr, 0);
    check("R1 arr_we reset", arr_we, 0);
    check("R1 rd_grant reset", rd_grant, 0);

    // R9: read granted when idle
    read_try(1, "R9 read granted idle");

    // R3/R5/R6: small write mid-page
    start_wr(13'h0105, 1, 1);
    send_byte(8'hA1, 1); send_byte(8'hB2, 1); send_byte(8'hC3, 1);
    end_wr(1, 1);
    measure_cycle("R6");

    // R3: wrap at top page from offset 30
    start_wr(13'h1FFE, 1, 1);
    for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i), 1);
    end_wr(1, 1);
    measure_cycle("R3");

    // R3: 34 bytes, first two overwritten
    start_wr(13'h0040, 1, 1);
    for (int i = 0; i < 34; i++) send_byte(8'(i * 7 + 3), 1);
    end_wr(1, 1);
    measure_cycle("R3 overwrite");

    // R4: misaligned rise cancels
    start_wr(13'h0200, 1, 0);
    send_byte(8'h55, 0);
    end_wr(0, 0);
    idle_watch("R4 misaligned cancel", 10);

    // R4: no bytes cancels
    start_wr(13'h0300, 1, 0);
    end_wr(1, 0);
    idle_watch("R4 empty cancel", 10);

    // R2: latch clear blocks transfer
    start_wr(13'h0400, 0, 0);
    send_byte(8'h66, 0);
    end_wr(1, 0);
    idle_watch("R2 wel low ignored", 10);

    // R8/R9: activity during write cycle
    start_wr(13'h0020, 1, 1);
    send_byte(8'h9C, 1);
    end_wr(1, 1);
    check("R5 wip set", wip, 1);
    read_try(0, "R9 read refused during wip");
    start_wr(13'h0600, 1, 0);
    send_byte(8'h77, 0);
    end_wr(1, 0);
    while (wip) @(negedge clk);
    check("R7 wel_clr after busy", wel_clr, 1);
    idle_watch("R8 ignored during wip", 15);
    check("R8 no extra writes", exp_q.size(), 0);
    read_try(1, "R9 read granted after wip");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule